// File: doc/BRIEF.md
# Multi-Channel Phase-Aligned PWM Generator

This block drives a bank of PWM outputs from one free-running system clock. Each channel has its own period, high time, phase offset and disable mode. Software or a host sequencer writes these through a simple per-channel register port. All timing is counted in system clock cycles, and no other clock affects the output frequency.

An external phase-alignment strobe is brought into the clock domain through a two-flop synchronizer. It is then reduced to a single-cycle rising-edge pulse. On that pulse every channel abandons its current period. Each channel then holds its output low for its own offset, in units of 32 clock cycles, before starting a fresh period.

A sticky flag records that an alignment event happened, and a read strobe clears it. When the active-high enable drops, each channel either forces its output low or freezes it, depending on its mode setting.

Top module: `sync_pwm_top`

## Requirements
- R1: A rising edge on `sync_i` is seen through two synchronizer flops. In the cycle after the internal pulse, every channel restarts. `sync_i` held high causes only one restart.
- R2: After a restart, a channel with offset value N > 0 drives its output low for N*32 cycles. It then begins a period at count 0. With N = 0 the period starts immediately.
- R3: In a running period the phase counter goes from 0 up to period-1 and wraps. The output is high while the count is below the duty value. `pwm_o` is registered and shows the level computed from the previous cycle's count.
- R4: `stat_sync_o` becomes 1 the cycle after an alignment pulse and stays 1 until a cycle with `stat_rd_i` high. It clears in the following cycle. If a pulse and a read fall in the same cycle, the flag stays 1.
- R5: While `rst_ni` is low, all outputs are 0 and the status flag is 0. Period, duty, offset and mode all return to 0, so every channel is low after reset.
- R6: While `en_i` is low, a channel whose mode is 0 drives 0. A channel whose mode is nonzero holds its last output value. Mode 0 is the reset default.
- R7: A duty of 0 keeps the output low. A duty equal to or above the period keeps it high, except during an offset delay.
- R8: Register writes use `cfg_sel_i` to choose the field: 0 = period, 1 = duty, 2 = offset, 3 = mode. `cfg_ch_i` selects the channel. A write changes only the addressed field of the addressed channel, and it takes effect the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, sole timing source |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Output enable, active high |
| sync_i | input | 1 | Asynchronous phase-alignment strobe |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_ch_i | input | CH_W (2) | Channel index for the write |
| cfg_sel_i | input | 2 | Field select for the write |
| cfg_data_i | input | CNT_W (16) | Write data |
| stat_rd_i | input | 1 | Status read strobe, clears the flag |
| stat_sync_o | output | 1 | Sticky alignment-event flag |
| pwm_o | output | NUM_CH (4) | PWM outputs |

## Verification
The checker watches several properties on every cycle. It confirms that the status flag sets after each internal alignment pulse and that a read clears it unless a pulse coincides. It confirms that outputs are off in reset and obey the off or freeze mode while enable is low. It also checks that a channel stays low during its offset delay and whenever its duty is zero.

Some behaviours can only be shown by the bench scenarios, which run against its reference model. These are the exact restart latency, the length of the offset delay, the high and low lengths of each period, and a level-held strobe causing only one restart. The same applies to write isolation between channels and to a register reset in mid-operation.

// File: rtl/sync_pwm_pkg.sv
package sync_pwm_pkg;
  typedef enum logic [1:0] {
    SEL_PERIOD = 2'd0,
    SEL_DUTY   = 2'd1,
    SEL_OFFSET = 2'd2,
    SEL_MODE   = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/sync_pwm_edge.sv
module sync_pwm_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic pulse_o
);
  // stages 0..STAGES-1 synchronize, stage STAGES keeps previous level
  logic [STAGES:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-1:0], async_i};
  end

  assign pulse_o = sync_q[STAGES-1] & ~sync_q[STAGES];
endmodule

// File: rtl/sync_pwm_status.sv
module sync_pwm_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic event_i,
  input  logic rd_i,
  output logic flag_o
);
  logic flag_q;

  // event wins over a coincident read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (event_i) flag_q <= 1'b1;
    else if (rd_i)    flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/sync_pwm_chan.sv
module sync_pwm_chan
  import sync_pwm_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int SCALE_LOG2 = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  cfg_sel_e         sel_i,
  input  logic [CNT_W-1:0] data_i,
  input  logic             sync_pulse_i,
  input  logic             en_i,
  output logic             pwm_o,
  output logic             hold_o,
  output logic             dzero_o,
  output logic             delay_o
);
  localparam int DLY_W = CNT_W + SCALE_LOG2;

  logic [CNT_W-1:0] period_q, duty_q, offset_q;
  logic             hold_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DLY_W-1:0] dly_q;
  logic             in_delay_q;
  logic             pwm_q;
  logic             raw;
  logic             wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      duty_q   <= '0;
      offset_q <= '0;
      hold_q   <= 1'b0;
    end else if (we_i) begin
      unique case (sel_i)
        SEL_PERIOD: period_q <= data_i;
        SEL_DUTY:   duty_q   <= data_i;
        SEL_OFFSET: offset_q <= data_i;
        SEL_MODE:   hold_q   <= |data_i;
        default:    ;
      endcase
    end
  end

  assign wrap = ({1'b0, cnt_q} + 1'b1) >= {1'b0, period_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      dly_q      <= '0;
      in_delay_q <= 1'b0;
    end else if (sync_pulse_i) begin
      cnt_q <= '0;
      if (offset_q != '0) begin
        in_delay_q <= 1'b1;
        dly_q      <= {offset_q, {SCALE_LOG2{1'b0}}};
      end else begin
        in_delay_q <= 1'b0;
      end
    end else if (in_delay_q) begin
      if (dly_q == DLY_W'(1)) begin
        in_delay_q <= 1'b0;
        cnt_q      <= '0;
      end else begin
        dly_q <= dly_q - 1'b1;
      end
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (in_delay_q || duty_q == '0) raw = 1'b0;
    else if (duty_q >= period_q)    raw = 1'b1;
    else                            raw = cnt_q < duty_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pwm_q <= 1'b0;
    else if (en_i)   pwm_q <= raw;
    else if (!hold_q) pwm_q <= 1'b0;
  end

  assign pwm_o   = pwm_q;
  assign hold_o  = hold_q;
  assign dzero_o = duty_q == '0;
  assign delay_o = in_delay_q;
endmodule

// File: rtl/sync_pwm_top.sv
module sync_pwm_top
  import sync_pwm_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int CNT_W      = 16,
  parameter int SCALE_LOG2 = 5,
  parameter int SYNC_STG   = 2,
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sync_i,
  input  logic              cfg_we_i,
  input  logic [CH_W-1:0]   cfg_ch_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [CNT_W-1:0]  cfg_data_i,
  input  logic              stat_rd_i,
  output logic              stat_sync_o,
  output logic [NUM_CH-1:0] pwm_o
);
  logic              sync_pulse;
  logic [NUM_CH-1:0] hold_v, dzero_v, delay_v;
  cfg_sel_e          sel;

  assign sel = cfg_sel_e'(cfg_sel_i);

  sync_pwm_edge #(.STAGES(SYNC_STG)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (sync_i),
    .pulse_o (sync_pulse)
  );

  sync_pwm_status u_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .event_i (sync_pulse),
    .rd_i    (stat_rd_i),
    .flag_o  (stat_sync_o)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic we;
    assign we = cfg_we_i && (cfg_ch_i == CH_W'(i));

    sync_pwm_chan #(.CNT_W(CNT_W), .SCALE_LOG2(SCALE_LOG2)) u_chan (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .we_i         (we),
      .sel_i        (sel),
      .data_i       (cfg_data_i),
      .sync_pulse_i (sync_pulse),
      .en_i         (en_i),
      .pwm_o        (pwm_o[i]),
      .hold_o       (hold_v[i]),
      .dzero_o      (dzero_v[i]),
      .delay_o      (delay_v[i])
    );
  end
endmodule

// File: rtl/sync_pwm_sva.sv
module sync_pwm_sva #(
  parameter int NUM_CH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              stat_rd_i,
  input logic              sync_pulse,
  input logic              stat_sync_o,
  input logic [NUM_CH-1:0] pwm_o,
  input logic [NUM_CH-1:0] hold_v,
  input logic [NUM_CH-1:0] dzero_v,
  input logic [NUM_CH-1:0] delay_v
);
  p_reset_quiet_r5: assert property (@(posedge clk_i)
    !rst_ni |-> (pwm_o == '0 && !stat_sync_o));

  p_flag_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_pulse |=> stat_sync_o);

  p_flag_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !sync_pulse) |=> !stat_sync_o);

  p_flag_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_sync_o && !stat_rd_i) |=> stat_sync_o);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    p_dis_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i && !hold_v[i]) |=> !pwm_o[i]);

    p_dis_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i && hold_v[i]) |=> $stable(pwm_o[i]));

    p_delay_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && delay_v[i]) |=> !pwm_o[i]);

    p_duty_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && dzero_v[i]) |=> !pwm_o[i]);
  end
endmodule

bind sync_pwm_top sync_pwm_sva #(.NUM_CH(NUM_CH)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .stat_rd_i   (stat_rd_i),
  .sync_pulse  (sync_pulse),
  .stat_sync_o (stat_sync_o),
  .pwm_o       (pwm_o),
  .hold_v      (hold_v),
  .dzero_v     (dzero_v),
  .delay_v     (delay_v)
);

// File: tb/sync_pwm_top_tb.sv
module sync_pwm_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        sync_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_ch_i = '0;
  logic [1:0]  cfg_sel_i = '0;
  logic [15:0] cfg_data_i = '0;
  logic        stat_rd_i = 1'b0;
  logic        stat_sync_o;
  logic [3:0]  pwm_o;

  int checks = 0;
  int fails = 0;
  string cur_req = "R5";

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sync_pwm_top u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .sync_i(sync_i),
    .cfg_we_i(cfg_we_i), .cfg_ch_i(cfg_ch_i), .cfg_sel_i(cfg_sel_i),
    .cfg_data_i(cfg_data_i), .stat_rd_i(stat_rd_i),
    .stat_sync_o(stat_sync_o), .pwm_o(pwm_o)
  );

  // behavioural reference model
  int m_per[NCH], m_duty[NCH], m_ofs[NCH], m_hold[NCH];
  int m_cnt[NCH], m_rem[NCH], m_wait[NCH], m_out[NCH];
  int m_flag;
  bit m_hist[$];

  task automatic m_clear();
    for (int c = 0; c < NCH; c++) begin
      m_per[c] = 0; m_duty[c] = 0; m_ofs[c] = 0; m_hold[c] = 0;
      m_cnt[c] = 0; m_rem[c] = 0; m_wait[c] = 0; m_out[c] = 0;
    end
    m_flag = 0;
    m_hist = '{0, 0, 0};
  endtask

  function automatic int level(int c);
    if (m_wait[c] != 0 || m_duty[c] == 0) return 0;
    if (m_duty[c] >= m_per[c]) return 1;
    return (m_cnt[c] < m_duty[c]) ? 1 : 0;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) m_clear();
    else begin
      bit ev;
      ev = m_hist[1] && !m_hist[2];
      m_hist.push_front(sync_i);
      void'(m_hist.pop_back());
      if (ev) m_flag = 1;
      else if (stat_rd_i) m_flag = 0;
      for (int c = 0; c < NCH; c++) begin
        if (en_i) m_out[c] = level(c);
        else if (m_hold[c] == 0) m_out[c] = 0;
        if (ev) begin
          m_cnt[c] = 0;
          m_wait[c] = (m_ofs[c] != 0);
          m_rem[c] = m_ofs[c] * 32;
        end else if (m_wait[c] != 0) begin
          if (m_rem[c] == 1) begin m_wait[c] = 0; m_cnt[c] = 0; end
          else m_rem[c]--;
        end else begin
          m_cnt[c] = (m_cnt[c] + 1 >= m_per[c]) ? 0 : m_cnt[c] + 1;
        end
      end
      if (cfg_we_i) begin
        case (cfg_sel_i)
          2'd0: m_per[cfg_ch_i] = cfg_data_i;
          2'd1: m_duty[cfg_ch_i] = cfg_data_i;
          2'd2: m_ofs[cfg_ch_i] = cfg_data_i;
          default: m_hold[cfg_ch_i] = (cfg_data_i != 0);
        endcase
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk_i) begin
    for (int c = 0; c < NCH; c++)
      check(cur_req, $sformatf("pwm_o[%0d]", c), int'(pwm_o[c]), m_out[c]);
    check(cur_req, "stat_sync_o", int'(stat_sync_o), m_flag);
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic wr(int ch, int sel, int data);
    cfg_we_i = 1'b1; cfg_ch_i = 2'(ch); cfg_sel_i = 2'(sel); cfg_data_i = 16'(data);
    tick(1);
    cfg_we_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    m_clear();
    cur_req = "R5";
    tick(3);
    check("R5", "pwm_o in reset", int'(pwm_o), 0);
    check("R5", "stat in reset", int'(stat_sync_o), 0);
    rst_ni = 1'b1;
    tick(2);

    cur_req = "R8";
    wr(0, 0, 10); wr(0, 1, 3);
    wr(1, 0, 8);  wr(1, 1, 4); wr(1, 2, 1);
    wr(2, 0, 6);  wr(2, 1, 0);
    wr(3, 0, 5);  wr(3, 1, 20);
    check("R8", "ch2 idle after ch1 writes", int'(pwm_o[2]), 0);
    en_i = 1'b1;
    cur_req = "R3";
    tick(30);
    cur_req = "R7";
    tick(10);

    cur_req = "R1";
    sync_i = 1'b1; tick(1); sync_i = 1'b0;
    tick(4);
    check("R4", "flag after sync", int'(stat_sync_o), 1);
    cur_req = "R2";
    tick(60);
    cur_req = "R4";
    stat_rd_i = 1'b1; tick(1); stat_rd_i = 1'b0;
    tick(1);
    check("R4", "flag after read", int'(stat_sync_o), 0);

    cur_req = "R1";
    wr(0, 2, 2);
    sync_i = 1'b1; tick(10);
    stat_rd_i = 1'b1; tick(1); stat_rd_i = 1'b0;
    tick(70);
    check("R1", "level-held strobe no re-trigger", int'(stat_sync_o), 0);
    sync_i = 1'b0; tick(5);

    cur_req = "R6";
    wr(1, 3, 1);
    wr(3, 3, 4);
    tick(3);
    en_i = 1'b0;
    tick(40);
    check("R6", "mode-0 channel off", int'(pwm_o[0]), 0);
    check("R6", "held channel 3 high", int'(pwm_o[3]), 1);
    en_i = 1'b1;
    tick(20);

    cur_req = "R4";
    sync_i = 1'b1; tick(2);
    stat_rd_i = 1'b1; tick(1); stat_rd_i = 1'b0;
    check("R4", "flag kept on coincident read", int'(stat_sync_o), 1);
    sync_i = 1'b0;
    tick(20);

    cur_req = "R5";
    rst_ni = 1'b0; tick(2);
    check("R5", "pwm_o mid reset", int'(pwm_o), 0);
    rst_ni = 1'b1;
    tick(20);
    check("R5", "ch3 config back to default", int'(pwm_o[3]), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule